// File: doc/BRIEF.md
# Power-Up Valid-Array Clearing Sequencer

After reset, this block clears the valid bits of six on-chip lookup arrays one entry per clock, so the caches and predictors start out empty. It does this in the background after reset is released instead of during reset itself. Two active-low reset inputs (a power-on reset and a system reset) are combined. The sweep starts on the first clock at which both are high, provided the previous clock saw at least one of them low.

Every array has its own index counter. All six sweeps run in parallel. The branch-target array, the history array and both translation buffers are always cleared. Two retain inputs, sampled when the sweep starts, can keep the level-1 data valid array or the level-2 valid array untouched, so that contents survive a power-down.

Requests to enable the level-2 cache or to run level-2 maintenance are held off until the level-2 sweep has finished. A sticky error flag reports a retain input that moved inside the stability window around the start.

Top module: `vclr_seq`

## Requirements
- R1: The sweep starts on the first rising clock edge at which `por_n` and `sys_n` are both sampled high, when the previous edge sampled either one low. From the next cycle, `clr_we` is high for every array that is being cleared.
- R2: The array at position g of `clr_we`, `clr_idx` and `arr_done` is cleared at indices 0, 1, …, D−1 in ascending order, one index per clock. Each index is written exactly once. Its `arr_done` bit goes high D+1 edges after the edge that starts the sweep. The positions and default depths D are: 0 target buffer (64), 1 history (128), 2 instruction translation buffer (32), 3 data translation buffer (32), 4 level-1 data valid (128), 5 level-2 valid (256).
- R3: Arrays 0 to 3 are always swept, whatever the retain inputs are.
- R4: If `keep_l1_i` is high at the start edge, array 4 receives no writes, and its `arr_done` bit is high one edge after the start.
- R5: If `keep_l2_i` is high at the start edge, array 5 receives no writes, and its `arr_done` bit is high one edge after the start.
- R6: A retain input that changes after the start edge has no effect on a sweep already in progress.
- R7: While `l2_en_req` or `l2_mnt_req` is high, or after either has been high since the last reset, `l2_hold` is high until `arr_done[5]` rises. It falls in the same cycle that `arr_done[5]` rises.
- R8: `all_done` is high exactly when all six `arr_done` bits are high.
- R9: While either reset input is low, then one edge later `clr_we`, `arr_done` and `all_done` are all zero. A reset that arrives during a sweep abandons it, and the next start runs a full sweep again.
- R10: `win_err` goes high one edge after the start edge if either retain input changed within the WIN (16) edges before the start. It also goes high if either retain input changes within the WIN edges after the start. It stays high until a reset input goes low, and it is otherwise low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on reset, active low |
| sys_n | input | 1 | System reset, active low |
| keep_l1_i | input | 1 | Retain the level-1 data valid array (array 4) |
| keep_l2_i | input | 1 | Retain the level-2 valid array (array 5) |
| l2_en_req | input | 1 | Level-2 enable request |
| l2_mnt_req | input | 1 | Level-2 maintenance request |
| clr_we | output | 6 | Per-array clear write enable |
| clr_idx | output | 6×8 | Per-array index being cleared |
| arr_done | output | 6 | Per-array sweep finished |
| all_done | output | 1 | Every array finished |
| l2_hold | output | 1 | Stall for level-2 enable and maintenance |
| win_err | output | 1 | Retain input moved inside the stability window |

## Verification
The bench counts writes per array and checks the exact edge on which each done bit rises. A counter that is off by one, that skips its last index, or that sweeps a retained array shows up as a wrong count, a wrong done cycle, or a cleared array that should have been kept.

A reset in the middle of a sweep must not leave a stale done bit behind, and the restarted sweep must cover the whole array. The stall has to outlive a one-cycle request and must drop exactly on the level-2 done edge.

The window check is driven from both sides: a change just before the start and a change just after it must both be flagged. A change well after the window must be ignored, and the sweep already in progress must not be affected by it.

// File: rtl/vclr_pkg.sv
package vclr_pkg;
   localparam int NARR  = 6;
   localparam int A_TGT = 0;
   localparam int A_HST = 1;
   localparam int A_ITB = 2;
   localparam int A_DTB = 3;
   localparam int A_L1V = 4;
   localparam int A_L2V = 5;

   function automatic int depth_pick(input int g, input int d0, input int d1,
                                     input int d2, input int d3, input int d4,
                                     input int d5);
      case (g)
         0: return d0;
         1: return d1;
         2: return d2;
         3: return d3;
         4: return d4;
         default: return d5;
      endcase
   endfunction

   function automatic int max6(input int d0, input int d1, input int d2,
                               input int d3, input int d4, input int d5);
      int m;
      m = d0;
      if (d1 > m) m = d1;
      if (d2 > m) m = d2;
      if (d3 > m) m = d3;
      if (d4 > m) m = d4;
      if (d5 > m) m = d5;
      return m;
   endfunction
endpackage

// File: rtl/vclr_sweep.sv
module vclr_sweep #(
   parameter int DEPTH = 64,
   parameter int IW    = 8
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          start,
   input  logic          skip,
   output logic          we,
   output logic [IW-1:0] idx,
   output logic          done
);
   localparam int CW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
   localparam logic [CW-1:0] LAST = CW'(DEPTH - 1);

   initial begin
      assert (DEPTH >= 2) else $error("vclr_sweep: DEPTH must be at least 2");
      assert (IW >= CW)   else $error("vclr_sweep: IW too narrow for DEPTH");
   end

   logic [CW-1:0] cnt;
   logic          busy;

   always_ff @(posedge clk) begin
      if (rst) begin
         cnt  <= '0;
         busy <= 1'b0;
         done <= 1'b0;
      end else if (start) begin
         cnt  <= '0;
         busy <= ~skip;
         done <= skip;
      end else if (busy) begin
         if (cnt == LAST) begin
            cnt  <= '0;
            busy <= 1'b0;
            done <= 1'b1;
         end else begin
            cnt <= cnt + 1'b1;
         end
      end
   end

   assign we = busy;

   generate
      if (CW == IW) begin : g_same
         assign idx = cnt;
      end else begin : g_pad
         assign idx = {{(IW-CW){1'b0}}, cnt};
      end
   endgenerate

   // R2: the index advances by exactly one per write until the last entry
   a_r2_idx_step: assert property (@(posedge clk) disable iff (rst)
      (we && idx != IW'(DEPTH - 1) && !start) |=> (we && idx == $past(idx) + 1'b1));

   // R2: done rises only right after the last index has been written
   a_r2_done_after_last: assert property (@(posedge clk) disable iff (rst)
      ($rose(done) && !$past(start)) |-> $past(we && idx == IW'(DEPTH - 1)));
endmodule

// File: rtl/vclr_guard.sv
module vclr_guard #(
   parameter int WIN = 16
) (
   input  logic       clk,
   input  logic       rst,
   input  logic       start,
   input  logic [1:0] keep,
   output logic       err
);
   localparam int SW = $clog2(WIN + 1);
   localparam logic [SW-1:0] WIN_V = SW'(WIN);

   initial assert (WIN >= 1) else $error("vclr_guard: WIN must be positive");

   logic [1:0]    prev;
   logic          chg;
   logic [SW-1:0] stab;
   logic [SW-1:0] post;

   assign chg = (keep != prev);

   always_ff @(posedge clk) begin
      prev <= keep;
      if (chg)               stab <= '0;
      else if (stab != WIN_V) stab <= stab + 1'b1;
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         post <= '0;
         err  <= 1'b0;
      end else if (start) begin
         post <= WIN_V;
         if (chg || stab < WIN_V) err <= 1'b1;
      end else if (post != '0) begin
         post <= post - 1'b1;
         if (chg) err <= 1'b1;
      end
   end

   // R10: the flag is only raised at a start or by an input change
   a_r10_err_cause: assert property (@(posedge clk) disable iff (rst)
      $rose(err) |-> $past(start || chg));
   // R10: once raised it stays until reset
   a_r10_sticky: assert property (@(posedge clk) disable iff (rst)
      err |=> err);
endmodule

// File: rtl/vclr_hold.sv
module vclr_hold (
   input  logic clk,
   input  logic rst,
   input  logic req_en,
   input  logic req_mnt,
   input  logic l2_done,
   output logic hold
);
   logic pend;
   logic req;

   assign req = req_en | req_mnt;

   always_ff @(posedge clk) begin
      if (rst) pend <= 1'b0;
      else     pend <= (pend | req) & ~l2_done;
   end

   assign hold = (pend | req) & ~l2_done;

   // R7: a request seen before level-2 completion keeps the stall up
   a_r7_hold_sticks: assert property (@(posedge clk) disable iff (rst)
      (req && !l2_done) |=> (hold || l2_done));
endmodule

// File: rtl/vclr_seq.sv
module vclr_seq
   import vclr_pkg::*;
#(
   parameter int TGT_DEPTH  = 64,
   parameter int HIST_DEPTH = 128,
   parameter int ITLB_DEPTH = 32,
   parameter int DTLB_DEPTH = 32,
   parameter int L1V_DEPTH  = 128,
   parameter int L2V_DEPTH  = 256,
   parameter int WIN        = 16,
   localparam int MAXD      = max6(TGT_DEPTH, HIST_DEPTH, ITLB_DEPTH,
                                   DTLB_DEPTH, L1V_DEPTH, L2V_DEPTH),
   localparam int IW        = (MAXD > 1) ? $clog2(MAXD) : 1
) (
   input  logic                     clk,
   input  logic                     por_n,
   input  logic                     sys_n,
   input  logic                     keep_l1_i,
   input  logic                     keep_l2_i,
   input  logic                     l2_en_req,
   input  logic                     l2_mnt_req,
   output logic [NARR-1:0]          clr_we,
   output logic [NARR-1:0][IW-1:0]  clr_idx,
   output logic [NARR-1:0]          arr_done,
   output logic                     all_done,
   output logic                     l2_hold,
   output logic                     win_err
);
   logic in_rst;
   logic rst_q;
   logic start;

   assign in_rst = ~(por_n & sys_n);

   always_ff @(posedge clk) rst_q <= in_rst;

   assign start = rst_q & ~in_rst;

   generate
      for (genvar g = 0; g < NARR; g++) begin : g_arr
         localparam int D = depth_pick(g, TGT_DEPTH, HIST_DEPTH, ITLB_DEPTH,
                                       DTLB_DEPTH, L1V_DEPTH, L2V_DEPTH);
         logic skip;
         if (g == A_L1V) begin : g_k1
            assign skip = keep_l1_i;
         end else if (g == A_L2V) begin : g_k2
            assign skip = keep_l2_i;
         end else begin : g_always
            assign skip = 1'b0;
         end

         vclr_sweep #(.DEPTH(D), .IW(IW)) u_sw (
            .clk  (clk),
            .rst  (in_rst),
            .start(start),
            .skip (skip),
            .we   (clr_we[g]),
            .idx  (clr_idx[g]),
            .done (arr_done[g])
         );
      end
   endgenerate

   assign all_done = &arr_done;

   vclr_hold u_hold (
      .clk    (clk),
      .rst    (in_rst),
      .req_en (l2_en_req),
      .req_mnt(l2_mnt_req),
      .l2_done(arr_done[A_L2V]),
      .hold   (l2_hold)
   );

   vclr_guard #(.WIN(WIN)) u_guard (
      .clk  (clk),
      .rst  (in_rst),
      .start(start),
      .keep ({keep_l2_i, keep_l1_i}),
      .err  (win_err)
   );

   // R1 / R3: the always-cleared arrays begin writing index 0 right after start
   a_r1_start: assert property (@(posedge clk) disable iff (in_rst)
      start |=> (clr_we[A_TGT] && clr_we[A_DTB] && clr_idx[A_TGT] == '0));
   // R4: a retained level-1 array is finished at once and never written
   a_r4_keep_l1: assert property (@(posedge clk) disable iff (in_rst)
      (start && keep_l1_i) |=> (arr_done[A_L1V] && !clr_we[A_L1V]));
   // R5: same for the level-2 array
   a_r5_keep_l2: assert property (@(posedge clk) disable iff (in_rst)
      (start && keep_l2_i) |=> (arr_done[A_L2V] && !clr_we[A_L2V]));
   // R9: a system reset silences every array on the next edge
   a_r9_quiet: assert property (@(posedge clk) disable iff (!por_n)
      !sys_n |=> (clr_we == '0 && arr_done == '0));
   // R8: global done never precedes level-2 completion
   a_r8_order: assert property (@(posedge clk) disable iff (in_rst)
      all_done |-> !l2_hold);
endmodule

// File: tb/sim_vclr_seq.sv
`timescale 1ns/1ps
module sim_vclr_seq;
   localparam int NA = 6;
   localparam int DEP [NA] = '{64, 128, 32, 32, 128, 256};

   logic clk = 1'b0;
   logic por_n = 1'b0, sys_n = 1'b0;
   logic keep_l1_i = 1'b0, keep_l2_i = 1'b0;
   logic l2_en_req = 1'b0, l2_mnt_req = 1'b0;
   logic [NA-1:0]        clr_we;
   logic [NA-1:0][7:0]   clr_idx;
   logic [NA-1:0]        arr_done;
   logic all_done, l2_hold, win_err;

   int n_chk = 0, n_bad = 0;
   logic fill_req = 1'b0;
   bit   mem [NA][256];
   int   wcnt [NA];
   int   order_bad [NA];
   int   last_idx [NA];

   always #5 clk = ~clk;

   vclr_seq u0 (.*);

   always @(posedge clk) begin
      for (int g = 0; g < NA; g++) begin
         if (fill_req) begin
            for (int i = 0; i < 256; i++) mem[g][i] <= 1'b1;
            wcnt[g] <= 0; order_bad[g] <= 0; last_idx[g] <= -1;
         end else if (clr_we[g]) begin
            mem[g][clr_idx[g]] <= 1'b0;
            wcnt[g] <= wcnt[g] + 1;
            if (int'(clr_idx[g]) != last_idx[g] + 1) order_bad[g] <= order_bad[g] + 1;
            last_idx[g] <= int'(clr_idx[g]);
         end
      end
   end

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic fill();
      @(negedge clk) fill_req = 1'b1;
      @(negedge clk) fill_req = 1'b0;
   endtask

   function automatic int ones(input int g);
      int n = 0;
      for (int i = 0; i < DEP[g]; i++) n += mem[g][i];
      return n;
   endfunction

   // hold reset with stable retain values, then release at a negedge
   task automatic hold_reset(input bit k1, input bit k2, input bit use_por);
      @(negedge clk);
      if (use_por) por_n = 1'b0; else sys_n = 1'b0;
      keep_l1_i = k1; keep_l2_i = k2;
      repeat (24) @(negedge clk);
      fill();
   endtask

   task automatic release_all();
      por_n = 1'b1; sys_n = 1'b1;
   endtask

   task automatic check_full(input bit k1, input bit k2, input string tag);
      for (int g = 0; g < NA; g++) begin
         bit kept = (g == 4 && k1) || (g == 5 && k2);
         chk(wcnt[g] == (kept ? 0 : DEP[g]), {tag, " write count"}, wcnt[g], kept ? 0 : DEP[g]);
         chk(ones(g) == (kept ? DEP[g] : 0), {tag, " array contents"}, ones(g), kept ? DEP[g] : 0);
         chk(order_bad[g] == 0, {tag, " R2 ascending order"}, order_bad[g], 0);
      end
   endtask

   task automatic t_reset_state();
      repeat (20) @(negedge clk);
      chk(clr_we == '0, "R9 no writes in reset", clr_we, 0);
      chk(arr_done == '0 && !all_done, "R9 done low in reset", arr_done, 0);
      chk(!win_err, "R10 no error in reset", win_err, 0);
      l2_en_req = 1'b1;
      @(negedge clk);
      chk(l2_hold, "R7 hold in reset", l2_hold, 1);
      l2_en_req = 1'b0;
   endtask

   task automatic t_full_sweep();
      hold_reset(0, 0, 1);
      release_all();
      @(negedge clk);
      chk(clr_we == 6'h3f, "R1 all arrays writing after start", clr_we, 6'h3f);
      repeat (63) @(negedge clk);
      chk(!arr_done[0], "R2 target array not done at D", arr_done[0], 0);
      @(negedge clk);
      chk(arr_done[0], "R2 target array done at D+1", arr_done[0], 1);
      repeat (191) @(negedge clk);
      chk(!arr_done[5] && !all_done, "R8 not done before level-2", all_done, 0);
      @(negedge clk);
      chk(arr_done[5] && all_done, "R8 all done after level-2", all_done, 1);
      chk(win_err == 0, "R10 clean start no error", win_err, 0);
      check_full(0, 0, "R2 R3 full sweep");
   endtask

   task automatic t_keep(input bit k1, input bit k2, input string tag);
      hold_reset(k1, k2, 0);
      release_all();
      @(negedge clk);
      chk(arr_done[4] == k1, {tag, " level-1 done at once"}, arr_done[4], k1);
      chk(arr_done[5] == k2, {tag, " level-2 done at once"}, arr_done[5], k2);
      repeat (300) @(negedge clk);
      chk(all_done, {tag, " all done"}, all_done, 1);
      check_full(k1, k2, {tag, " R3"});
   endtask

   task automatic t_stall();
      hold_reset(0, 0, 1);
      release_all();
      repeat (10) @(negedge clk);
      l2_mnt_req = 1'b1;
      #1 chk(l2_hold, "R7 hold with request", l2_hold, 1);
      @(negedge clk) l2_mnt_req = 1'b0;
      #1 chk(l2_hold, "R7 hold after request drops", l2_hold, 1);
      repeat (245) @(negedge clk);
      chk(l2_hold && !arr_done[5], "R7 hold until level-2 done", l2_hold, 1);
      @(negedge clk);
      chk(!l2_hold && arr_done[5], "R7 hold falls on done", l2_hold, 0);
      l2_en_req = 1'b1;
      #1 chk(!l2_hold, "R7 no hold once done", l2_hold, 0);
      @(negedge clk) l2_en_req = 1'b0;
   endtask

   task automatic t_midreset();
      hold_reset(0, 0, 1);
      release_all();
      repeat (70) @(negedge clk);
      chk(arr_done[0], "R9 target done before abort", arr_done[0], 1);
      sys_n = 1'b0;
      @(negedge clk);
      chk(clr_we == '0 && arr_done == '0, "R9 abort clears", arr_done, 0);
      repeat (24) @(negedge clk);
      fill();
      release_all();
      repeat (257) @(negedge clk);
      chk(all_done, "R9 restart completes", all_done, 1);
      check_full(0, 0, "R9 restart full");
   endtask

   task automatic t_window();
      hold_reset(0, 0, 1);
      repeat (5) @(negedge clk);
      keep_l1_i = 1'b1;
      repeat (4) @(negedge clk);
      keep_l1_i = 1'b0;
      repeat (4) @(negedge clk);
      release_all();
      @(negedge clk);
      chk(win_err, "R10 change before start flagged", win_err, 1);
      hold_reset(0, 0, 0);
      release_all();
      repeat (5) @(negedge clk);
      chk(!win_err, "R10 no error before change", win_err, 0);
      keep_l1_i = 1'b1;
      repeat (2) @(negedge clk);
      chk(win_err, "R10 change after start flagged", win_err, 1);
      repeat (300) @(negedge clk);
      chk(win_err, "R10 error is sticky", win_err, 1);
      check_full(0, 0, "R6 late keep_l1 ignored");
      keep_l1_i = 1'b0;
   endtask

   task automatic t_late_change();
      hold_reset(0, 0, 1);
      release_all();
      repeat (40) @(negedge clk);
      keep_l2_i = 1'b1;
      repeat (260) @(negedge clk);
      chk(!win_err, "R10 change outside window ignored", win_err, 1'b0);
      chk(wcnt[5] == 256, "R6 level-2 still swept", wcnt[5], 256);
      keep_l2_i = 1'b0;
   endtask

   initial begin
      for (int g = 0; g < NA; g++) begin wcnt[g] = 0; order_bad[g] = 0; last_idx[g] = -1; end
      t_reset_state();
      t_full_sweep();
      t_keep(1, 0, "R4");
      t_keep(0, 1, "R5");
      t_keep(1, 1, "R4 R5 both");
      t_stall();
      t_midreset();
      t_window();
      t_late_change();
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      n_chk++; n_bad++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end
endmodule